// File: doc/BRIEF.md
# Bit-Serial Display Memory Load Port

This block lets a host processor with no serial port of its own load a serial display memory, and then stream that memory out as pixels. Every host store to the block's strobe address updates a small control register from the low nibble of the data byte. The same store can also shift one bit, taken from the byte's most significant bit, into the memory's serial input. A transaction is sent one bit per store: a command byte, two address bytes, then any number of data bytes. A frame tracker follows the transaction, assembles each byte and reports which part of the transaction is being sent.

In streaming mode the serial clock comes from a free-running fast tick instead of the host strobe. The memory's serial output is sampled on each tick and turned into pixels, either one bit per pixel (monochrome) or two bits per pixel (four grey levels). Loading is only allowed while the display is in blanking. Streaming is only allowed while displayed lines are active. A host store that arrives in the wrong mode or window sets a sticky error flag and has no other effect on the serial side.

The serial clock is modelled as a one-cycle pulse in the system clock domain. The fast tick is a one-cycle enable. The choice of clock source can only change while the memory is deselected, so the clock never switches in the middle of a transaction.

Top module: `serwr_port`

## Requirements
- R1: After reset, chip select is high (deasserted), the clock source is the host strobe (stream_mode = 0), bank_sel = 0, vid_mode = 0, err = 0, no serial clock pulse, bit_cnt = 0 and phase = 0.
- R2: Each strobe latches data bit 0 into bank_sel, bit 3 into vid_mode and bit 2 into mem_cs_n (1 = deasserted). All three are visible one cycle after the strobe.
- R3: Data bit 1 selects the clock source (0 = host strobe, 1 = fast stream tick). It is accepted only if mem_cs_n was already high when the strobe arrived; otherwise the previous source is kept.
- R4: In host-strobe mode, during blanking (line_active = 0), a strobe that keeps an already low chip select low gives exactly one mem_sck pulse in the next cycle, with mem_si equal to data bit 7. A strobe that first lowers chip select gives no pulse.
- R5: Shifted bits form bytes MSB first. After the eighth bit, rx_valid pulses with the byte in rx_byte in the same cycle as the last mem_sck pulse. phase then steps 0 (command) to 1 (address high) to 2 (address low) to 3 (data), and stays at 3 for every further byte.
- R6: Raising chip select ends the transaction. One cycle later, bit_cnt and phase are back to 0, and any partly sent byte is discarded.
- R7: In stream mode with chip select low, each fast_tick during line_active gives one mem_sck pulse in the next cycle. A tick while line_active = 0 gives no pulse.
- R8: A strobe that keeps chip select low while in stream mode, or while line_active = 1, sets err and gives no mem_sck pulse. err stays set until a strobe with bit 2 = 1.
- R9: With vid_mode = 0, each stream tick produces, one cycle later, pix_valid = 1 and pix = {mem_so, mem_so}.
- R10: With vid_mode = 1, two stream ticks make one pixel: the first sampled bit is pix[1], the second is pix[0]. pix_valid pulses one cycle after every second tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | One-cycle host store strobe at the decoded address |
| wr_data | input | 8 | Host store data: bit 7 serial bit, bits 3..0 control |
| fast_tick | input | 1 | Free-running stream clock enable |
| line_active | input | 1 | High during displayed scan lines |
| mem_so | input | 1 | Serial output from the display memory |
| bank_sel | output | 1 | Cartridge bank select |
| vid_mode | output | 1 | 0 = one bit per pixel, 1 = two bits per pixel |
| stream_mode | output | 1 | Current clock source, 1 = stream tick |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_sck | output | 1 | Serial clock pulse to the memory |
| mem_si | output | 1 | Serial data to the memory |
| err | output | 1 | Sticky wrong-mode store flag |
| bit_cnt | output | 3 | Bit position within the current byte |
| phase | output | 2 | Transaction part: 0 command, 1 addr high, 2 addr low, 3 data |
| rx_byte | output | 8 | Last completed byte sent to the memory |
| rx_valid | output | 1 | One-cycle pulse when rx_byte is updated |
| pix | output | 2 | Pixel value from the stream |
| pix_valid | output | 1 | One-cycle pulse when pix is updated |

## Verification
Control fields, the serial clock pulse, serial data, err, rx_valid and the pixel outputs all appear at the first rising edge after the strobe or tick is sampled. The bench drives each stimulus on a falling edge, releases it on the next falling edge, and checks those outputs right then, when the pulse outputs are high for their single cycle. The tracker reset after chip select rises comes one cycle later, so the bench waits an extra falling edge before checking bit_cnt and phase. A two-bit grey pixel is checked only after the second tick of a pair, and the first tick of the pair is checked to give no pix_valid.

// File: rtl/serwr_pkg.sv
package serwr_pkg;
  localparam int unsigned HOST_W  = 8;
  localparam int unsigned F_BANK  = 0;
  localparam int unsigned F_SRC   = 1;
  localparam int unsigned F_CSN   = 2;
  localparam int unsigned F_MODE  = 3;
  localparam int unsigned F_SDAT  = HOST_W - 1;

  typedef enum logic [1:0] {
    PH_CMD  = 2'd0,
    PH_AHI  = 2'd1,
    PH_ALO  = 2'd2,
    PH_DATA = 2'd3
  } phase_e;

  typedef struct packed {
    logic mode;
    logic csn;
    logic src;
    logic bank;
  } ctrl_t;
endpackage

// File: rtl/serwr_ctrl.sv
module serwr_ctrl
  import serwr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [HOST_W-1:0] wr_data,
  input  logic              line_active,
  input  logic              fast_tick,
  output ctrl_t             ctrl,
  output logic              err,
  output logic              shift_en,
  output logic              shift_bit,
  output logic              tick_en
);
  ctrl_t ctrl_q, ctrl_d;
  logic  err_q, err_d;
  logic  keep_low, bad_store;

  always_comb begin
    keep_low  = wr_stb & ~ctrl_q.csn & ~wr_data[F_CSN];
    shift_en  = keep_low & ~ctrl_q.src & ~line_active;
    bad_store = keep_low & (ctrl_q.src | line_active);
    shift_bit = wr_data[F_SDAT];
    tick_en   = ctrl_q.src & ~ctrl_q.csn & line_active & fast_tick & ~wr_stb;

    ctrl_d = ctrl_q;
    if (wr_stb) begin
      ctrl_d.bank = wr_data[F_BANK];
      ctrl_d.mode = wr_data[F_MODE];
      ctrl_d.csn  = wr_data[F_CSN];
      if (ctrl_q.csn) ctrl_d.src = wr_data[F_SRC];
    end

    err_d = err_q;
    if (wr_stb && wr_data[F_CSN]) err_d = 1'b0;
    else if (bad_store)           err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '{mode: 1'b0, csn: 1'b1, src: 1'b0, bank: 1'b0};
      err_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      err_q  <= err_d;
    end
  end

  assign ctrl = ctrl_q;
  assign err  = err_q;

  // R3
  src_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.csn && $past(!ctrl_q.csn)) |-> $stable(ctrl_q.src));

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !(wr_stb && wr_data[F_CSN])) |=> err_q);
endmodule

// File: rtl/serwr_frame.sv
module serwr_frame
  import serwr_pkg::*;
#(
  parameter int unsigned BYTE_BITS = 8,
  localparam int unsigned BW = $clog2(BYTE_BITS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_n,
  input  logic                 shift_en,
  input  logic                 shift_bit,
  output logic [BW-1:0]        bit_idx,
  output phase_e               phase,
  output logic [BYTE_BITS-1:0] rx_byte,
  output logic                 rx_valid
);
  localparam logic [BW-1:0] LAST_IDX = BW'(BYTE_BITS - 1);

  logic [BW-1:0]        idx_q, idx_d;
  phase_e               ph_q, ph_d;
  logic [BYTE_BITS-1:0] sreg_q, sreg_d;
  logic [BYTE_BITS-1:0] byte_q, byte_d;
  logic                 vld_q, vld_d;

  always_comb begin
    idx_d  = idx_q;
    ph_d   = ph_q;
    sreg_d = sreg_q;
    byte_d = byte_q;
    vld_d  = 1'b0;
    if (cs_n) begin
      idx_d = '0;
      ph_d  = PH_CMD;
    end else if (shift_en) begin
      sreg_d = {sreg_q[BYTE_BITS-2:0], shift_bit};
      if (idx_q == LAST_IDX) begin
        idx_d  = '0;
        byte_d = sreg_d;
        vld_d  = 1'b1;
        if (ph_q != PH_DATA) ph_d = phase_e'(ph_q + 2'd1);
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      ph_q   <= PH_CMD;
      sreg_q <= '0;
      byte_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      idx_q  <= idx_d;
      ph_q   <= ph_d;
      sreg_q <= sreg_d;
      byte_q <= byte_d;
      vld_q  <= vld_d;
    end
  end

  assign bit_idx  = idx_q;
  assign phase    = ph_q;
  assign rx_byte  = byte_q;
  assign rx_valid = vld_q;

  // R6
  cs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (idx_q == '0 && ph_q == PH_CMD));

  // R5
  data_phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_DATA && !cs_n) |=> ph_q == PH_DATA);

  // R5
  valid_from_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> $past(shift_en));
endmodule

// File: rtl/serwr_unpack.sv
module serwr_unpack #(
  parameter int unsigned PIX_W = 2,
  localparam int unsigned CW = $clog2(PIX_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             mode,
  input  logic             tick,
  input  logic             so,
  output logic [PIX_W-1:0] pix,
  output logic             pix_valid
);
  localparam logic [CW-1:0] LAST_CNT = CW'(PIX_W - 1);

  logic [CW-1:0]    cnt_q, cnt_d;
  logic [PIX_W-1:0] acc_q, acc_d;
  logic [PIX_W-1:0] pix_q, pix_d;
  logic             vld_q, vld_d;

  always_comb begin
    cnt_d = cnt_q;
    acc_d = acc_q;
    pix_d = pix_q;
    vld_d = 1'b0;
    if (cs_n) begin
      cnt_d = '0;
    end else if (tick) begin
      if (!mode) begin
        pix_d = {PIX_W{so}};
        vld_d = 1'b1;
        cnt_d = '0;
      end else if (cnt_q == LAST_CNT) begin
        pix_d = {acc_q[PIX_W-2:0], so};
        vld_d = 1'b1;
        cnt_d = '0;
      end else begin
        acc_d = {acc_q[PIX_W-2:0], so};
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      acc_q <= '0;
      pix_q <= '0;
      vld_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      acc_q <= acc_d;
      pix_q <= pix_d;
      vld_q <= vld_d;
    end
  end

  assign pix       = pix_q;
  assign pix_valid = vld_q;

  // R9
  mono_pix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cs_n && !mode) |=> (vld_q && pix_q == {PIX_W{$past(so)}}));
endmodule

// File: rtl/serwr_port.sv
module serwr_port
  import serwr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_stb,
  input  logic [7:0]  wr_data,
  input  logic        fast_tick,
  input  logic        line_active,
  input  logic        mem_so,
  output logic        bank_sel,
  output logic        vid_mode,
  output logic        stream_mode,
  output logic        mem_cs_n,
  output logic        mem_sck,
  output logic        mem_si,
  output logic        err,
  output logic [2:0]  bit_cnt,
  output logic [1:0]  phase,
  output logic [7:0]  rx_byte,
  output logic        rx_valid,
  output logic [1:0]  pix,
  output logic        pix_valid
);
  ctrl_t  ctrl;
  logic   shift_en, shift_bit, tick_en;
  phase_e ph;
  logic   sck_q, sck_d, si_q, si_d;

  serwr_ctrl i_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
    .line_active(line_active), .fast_tick(fast_tick), .ctrl(ctrl),
    .err(err), .shift_en(shift_en), .shift_bit(shift_bit), .tick_en(tick_en)
  );

  serwr_frame #(.BYTE_BITS(HOST_W)) i_frame (
    .clk(clk), .rst_n(rst_n), .cs_n(ctrl.csn), .shift_en(shift_en),
    .shift_bit(shift_bit), .bit_idx(bit_cnt), .phase(ph),
    .rx_byte(rx_byte), .rx_valid(rx_valid)
  );

  serwr_unpack #(.PIX_W(2)) i_unpack (
    .clk(clk), .rst_n(rst_n), .cs_n(ctrl.csn), .mode(ctrl.mode),
    .tick(tick_en), .so(mem_so), .pix(pix), .pix_valid(pix_valid)
  );

  always_comb begin
    sck_d = shift_en | tick_en;
    si_d  = shift_en ? shift_bit : si_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      si_q  <= 1'b0;
    end else begin
      sck_q <= sck_d;
      si_q  <= si_d;
    end
  end

  assign bank_sel    = ctrl.bank;
  assign vid_mode    = ctrl.mode;
  assign stream_mode = ctrl.src;
  assign mem_cs_n    = ctrl.csn;
  assign mem_sck     = sck_q;
  assign mem_si      = si_q;
  assign phase       = ph;

  // R4
  sck_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_sck |-> !mem_cs_n);

  // R7
  stream_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_sck && stream_mode) |-> $past(line_active));
endmodule

// File: tb/test_serwr_port.sv
module test_serwr_port;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_stb, fast_tick, line_active, mem_so;
  logic [7:0] wr_data;
  logic       bank_sel, vid_mode, stream_mode, mem_cs_n, mem_sck, mem_si, err;
  logic [2:0] bit_cnt;
  logic [1:0] phase;
  logic [7:0] rx_byte;
  logic       rx_valid;
  logic [1:0] pix;
  logic       pix_valid;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serwr_port i_serwr_port (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
    .fast_tick(fast_tick), .line_active(line_active), .mem_so(mem_so),
    .bank_sel(bank_sel), .vid_mode(vid_mode), .stream_mode(stream_mode),
    .mem_cs_n(mem_cs_n), .mem_sck(mem_sck), .mem_si(mem_si), .err(err),
    .bit_cnt(bit_cnt), .phase(phase), .rx_byte(rx_byte), .rx_valid(rx_valid),
    .pix(pix), .pix_valid(pix_valid)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic store(input logic [7:0] d);
    @(negedge clk);
    wr_stb  = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_stb  = 1'b0;
  endtask

  task automatic tick(input logic b);
    @(negedge clk);
    fast_tick = 1'b1;
    mem_so    = b;
    @(negedge clk);
    fast_tick = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v, input logic [1:0] exp_phase);
    for (int i = 7; i >= 0; i--) begin
      store({v[i], 7'h00});
      chk("R4 sck pulse", mem_sck, 1);
      chk("R4 si bit", mem_si, v[i]);
    end
    chk("R5 rx_valid", rx_valid, 1);
    chk("R5 rx_byte", rx_byte, v);
    chk("R5 phase", phase, exp_phase);
  endtask

  task automatic t_reset();
    chk("R1 cs_n", mem_cs_n, 1);
    chk("R1 stream_mode", stream_mode, 0);
    chk("R1 bank", bank_sel, 0);
    chk("R1 vid_mode", vid_mode, 0);
    chk("R1 err", err, 0);
    chk("R1 sck", mem_sck, 0);
    chk("R1 bit_cnt", bit_cnt, 0);
    chk("R1 phase", phase, 0);
  endtask

  task automatic t_fields();
    store(8'h0D);
    chk("R2 bank", bank_sel, 1);
    chk("R2 vid_mode", vid_mode, 1);
    chk("R2 cs_n", mem_cs_n, 1);
    store(8'h04);
    chk("R2 bank clear", bank_sel, 0);
    chk("R2 vid_mode clear", vid_mode, 0);
  endtask

  task automatic t_load();
    store(8'h00);
    chk("R4 first low no sck", mem_sck, 0);
    chk("R2 cs_n low", mem_cs_n, 0);
    send_byte(8'h06, 2'd1);
    send_byte(8'h12, 2'd2);
    send_byte(8'h34, 2'd3);
    send_byte(8'hA5, 2'd3);
    send_byte(8'h5A, 2'd3);
    @(negedge clk);
    chk("R4 single pulse", mem_sck, 0);
  endtask

  task automatic t_abort();
    store(8'h80);
    store(8'h00);
    store(8'h80);
    chk("R6 mid bit_cnt", bit_cnt, 3);
    store(8'h04);
    @(negedge clk);
    chk("R6 bit_cnt clear", bit_cnt, 0);
    chk("R6 phase clear", phase, 0);
    store(8'h00);
    send_byte(8'hC3, 2'd1);
    store(8'h04);
  endtask

  task automatic t_display_store();
    store(8'h00);
    line_active = 1'b1;
    store(8'h80);
    chk("R8 no sck in display", mem_sck, 0);
    chk("R8 err set", err, 1);
    line_active = 1'b0;
    store(8'h00);
    chk("R8 err sticky", err, 1);
    store(8'h04);
    chk("R8 err cleared", err, 0);
  endtask

  task automatic t_stream_mono();
    logic [3:0] pat;
    pat = 4'b1011;
    store(8'h06);
    chk("R3 src taken", stream_mode, 1);
    store(8'h02);
    line_active = 1'b1;
    for (int i = 0; i < 4; i++) begin
      tick(pat[i]);
      chk("R7 stream sck", mem_sck, 1);
      chk("R9 pix_valid", pix_valid, 1);
      chk("R9 pix", pix, {pat[i], pat[i]});
    end
    line_active = 1'b0;
    tick(1'b1);
    chk("R7 no sck off display", mem_sck, 0);
    chk("R9 no pix off display", pix_valid, 0);
  endtask

  task automatic t_stream_gray();
    logic [5:0] pat;
    pat = 6'b11_01_10;
    store(8'h0E);
    store(8'h0A);
    chk("R2 mode gray", vid_mode, 1);
    line_active = 1'b1;
    for (int p = 0; p < 3; p++) begin
      tick(pat[2*p+1]);
      chk("R10 half no valid", pix_valid, 0);
      tick(pat[2*p]);
      chk("R10 pix_valid", pix_valid, 1);
      chk("R10 pix", pix, {pat[2*p+1], pat[2*p]});
    end
    store(8'h8A);
    chk("R8 stream store no sck", mem_sck, 0);
    chk("R8 stream store err", err, 1);
    line_active = 1'b0;
  endtask

  task automatic t_src_lock();
    store(8'h08);
    chk("R3 src locked while cs low", stream_mode, 1);
    store(8'h0C);
    chk("R8 err cleared on cs rise", err, 0);
    chk("R3 src kept at cs rise", stream_mode, 1);
    store(8'h04);
    chk("R3 src change while deselected", stream_mode, 0);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    failures++;
    $display("FAIL watchdog R1 actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    wr_stb = 1'b0;
    wr_data = 8'h00;
    fast_tick = 1'b0;
    line_active = 1'b0;
    mem_so = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fields();
    t_load();
    t_abort();
    t_display_store();
    t_stream_mono();
    t_stream_gray();
    t_src_lock();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule